// File: doc/BRIEF.md
# Single-Transfer Wishbone Master Gateway

This block connects a processor's load, store and fetch request port to an external Wishbone B4 master interface. Each request comes with an address, write data, byte enables, a write flag and three attribute flags: instruction fetch, privileged mode and load-reserved. The block first checks the address against four internal windows given as parameters: instruction memory, data memory, boot ROM and IO. A request that hits any of these windows belongs to on-chip logic, so the gateway starts no bus cycle for it and sends no response. Every other request becomes exactly one Wishbone transfer. Only one transfer is ever in flight, so there is no STALL input and no burst.

Parameters choose the strobe protocol (classic or pipelined), the byte order on the bus (little or big-endian) and the response path (registered or direct). A countdown parameter ends a transfer that the slave never acknowledges and reports it as a bus fault; a value of zero turns the countdown off. The bus also carries a 3-bit access-type tag and a lock flag that marks a reservation sequence.

Top module: `wbg_master`

## Requirements
- R1: A request whose address lies in any of the four internal windows (base <= address < base + size) starts no bus cycle and produces no response. An address just past the end of a window is forwarded.
- R2: An accepted request raises CYC in the next cycle. CYC stays high until the cycle in which ACK or ERR is sampled, or until the timeout fires. While CYC is high, address, write flag, byte select, write data, tag and lock do not change.
- R3: In classic mode (PIPELINED = 0), STB is high in exactly the cycles in which CYC is high.
- R4: In pipelined mode (PIPELINED = 1), STB is high only in the first CYC cycle of each transfer and low otherwise.
- R5: With the registered response path (ASYNC_RX = 0), the response pulse comes one cycle after the cycle in which ACK or ERR is high. With the direct path (ASYNC_RX = 1), it comes in that same cycle.
- R6: With TIMEOUT = T > 0, a transfer that gets no ACK or ERR keeps CYC high for exactly T cycles, then drops it. The response follows one cycle later with the error flag set. An ACK in CYC cycle T is still accepted.
- R7: ERR sampled while CYC is high ends the transfer. The response then carries the error flag set and read data of zero.
- R8: Tag bit 0 equals the privileged flag, bit 1 is always 0, and bit 2 equals the instruction-fetch flag.
- R9: Every request, forwarded or internal, loads the lock output from its load-reserved flag. The lock holds that value until the next request. ERR during a locked transfer is returned as an error.
- R10: With BIG_ENDIAN = 1, bus byte lane i carries requester byte lane 3-i. This applies to write data, to read data, and to select bit i, which is request enable bit 3-i. With BIG_ENDIAN = 0, lanes pass straight through.
- R11: Each forwarded request yields exactly one single-cycle response. ACK or ERR that arrives while CYC is low produces no response.
- R12: The write flag, write data and byte select of a request appear on the bus. On ACK without ERR, the response carries the bus input data, after the lane mapping of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, one cycle, only while no response is pending |
| req_addr_i | input | AW | Request byte address |
| req_wdata_i | input | DW | Write data, requester byte order |
| req_be_i | input | DW/8 | Byte enables, requester order |
| req_we_i | input | 1 | 1 = store, 0 = load or fetch |
| req_fetch_i | input | 1 | Instruction fetch access |
| req_priv_i | input | 1 | Privileged-mode access |
| req_lr_i | input | 1 | Load-reserved access, sets the lock |
| rsp_valid_o | output | 1 | Completion pulse |
| rsp_rdata_o | output | DW | Read data (zero on error) |
| rsp_err_o | output | 1 | Bus fault: ERR or timeout |
| wb_adr_o | output | AW | Bus address |
| wb_dat_o | output | DW | Bus write data |
| wb_sel_o | output | DW/8 | Bus byte select |
| wb_we_o | output | 1 | Bus write enable |
| wb_tag_o | output | 3 | Access-type tag |
| wb_stb_o | output | 1 | Bus strobe |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_lock_o | output | 1 | Reservation lock |
| wb_dat_i | input | DW | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |
| wb_err_i | input | 1 | Bus error |

## Verification
Two instances run side by side. One uses classic strobes, little-endian lanes, the registered response path and a 16-cycle timeout. The other uses pipelined strobes, big-endian lanes, the direct response path and a 5-cycle timeout. Because of this split, a lane-order mistake, a strobe-shape mistake or a response that is one cycle off each shows up in one instance and not in the other.

Random accesses vary the address, data, enables, attribute flags, slave latency and error or silence. The slave latency tells the ACK path apart from the timeout path, including the corner case of an ACK in the very last allowed cycle. Directed cases probe addresses at and just past each window edge, lock persistence across idle cycles and internal requests, and stray ACK or ERR after an abort.

// File: rtl/wbg_pkg.sv
package wbg_pkg;

  localparam int TAG_W        = 3;
  localparam int TAG_PRIV_BIT = 0;
  localparam int TAG_NSEC_BIT = 1;
  localparam int TAG_INSN_BIT = 2;
  localparam int NUM_WIN      = 4;

  // Builds the access-type tag; the security bit always reads as secure (0).
  function automatic logic [TAG_W-1:0] make_tag(input logic priv, input logic fetch);
    logic [TAG_W-1:0] t;
    t               = '0;
    t[TAG_PRIV_BIT] = priv;
    t[TAG_NSEC_BIT] = 1'b0;
    t[TAG_INSN_BIT] = fetch;
    return t;
  endfunction

endpackage

// File: rtl/wbg_win_match.sv
module wbg_win_match #(
  parameter int            AW   = 32,
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [AW-1:0] SIZE = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);

  logic [AW-1:0] offset;

  assign offset = addr_i - BASE;
  assign hit_o  = (addr_i >= BASE) && (offset < SIZE);

endmodule

// File: rtl/wbg_lane_swap.sv
module wbg_lane_swap #(
  parameter int W       = 32,
  parameter int LANE    = 8,
  parameter bit REVERSE = 1'b0
) (
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);

  localparam int N = W / LANE;

  if (REVERSE) begin : g_rev
    for (genvar i = 0; i < N; i++) begin : g_lane
      assign dout_o[i*LANE +: LANE] = din_i[(N-1-i)*LANE +: LANE];
    end
  end else begin : g_thru
    assign dout_o = din_i;
  end

endmodule

// File: rtl/wbg_watchdog.sv
module wbg_watchdog #(
  parameter int TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);

  localparam int            CW     = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LOAD   = CW'(TIMEOUT);
  localparam bit            ENABLE = (TIMEOUT > 0);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = LOAD;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = ENABLE && run_i && !kick_i && (cnt_q == CW'(1));

  // R6: the remaining budget never exceeds the configured window
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);

  // R6: an expiry is followed by a new start only via a fresh request, never a re-fire
  a_r6_single_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);

endmodule

// File: rtl/wbg_master.sv
module wbg_master
  import wbg_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            DW         = 32,
  parameter bit            PIPELINED  = 1'b0,
  parameter bit            BIG_ENDIAN = 1'b0,
  parameter bit            ASYNC_RX   = 1'b0,
  parameter int            TIMEOUT    = 16,
  parameter logic [AW-1:0] IMEM_BASE  = 32'h0000_0000,
  parameter logic [AW-1:0] IMEM_SIZE  = 32'h0000_8000,
  parameter logic [AW-1:0] DMEM_BASE  = 32'h8000_0000,
  parameter logic [AW-1:0] DMEM_SIZE  = 32'h0000_2000,
  parameter logic [AW-1:0] BOOT_BASE  = 32'hFFFF_0000,
  parameter logic [AW-1:0] BOOT_SIZE  = 32'h0000_8000,
  parameter logic [AW-1:0] IO_BASE    = 32'hFFFF_FE00,
  parameter logic [AW-1:0] IO_SIZE    = 32'h0000_0200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [DW/8-1:0]   req_be_i,
  input  logic              req_we_i,
  input  logic              req_fetch_i,
  input  logic              req_priv_i,
  input  logic              req_lr_i,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic              rsp_err_o,
  output logic [AW-1:0]     wb_adr_o,
  output logic [DW-1:0]     wb_dat_o,
  output logic [DW/8-1:0]   wb_sel_o,
  output logic              wb_we_o,
  output logic [2:0]        wb_tag_o,
  output logic              wb_stb_o,
  output logic              wb_cyc_o,
  output logic              wb_lock_o,
  input  logic [DW-1:0]     wb_dat_i,
  input  logic              wb_ack_i,
  input  logic              wb_err_i
);

  localparam int NB = DW / 8;

  localparam logic [NUM_WIN-1:0][AW-1:0] WIN_BASE = {IO_BASE, BOOT_BASE, DMEM_BASE, IMEM_BASE};
  localparam logic [NUM_WIN-1:0][AW-1:0] WIN_SIZE = {IO_SIZE, BOOT_SIZE, DMEM_SIZE, IMEM_SIZE};

  // ---------------- address filter ----------------
  logic [NUM_WIN-1:0] win_hit;
  logic               internal;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    wbg_win_match #(
      .AW   (AW),
      .BASE (WIN_BASE[w]),
      .SIZE (WIN_SIZE[w])
    ) u_match (
      .addr_i (req_addr_i),
      .hit_o  (win_hit[w])
    );
  end

  assign internal = |win_hit;

  // ---------------- lane mapping ----------------
  logic [DW-1:0] tx_dat_sw, rx_dat_sw;
  logic [NB-1:0] tx_sel_sw;

  wbg_lane_swap #(.W(DW), .LANE(8), .REVERSE(BIG_ENDIAN)) u_swap_txd (
    .din_i  (req_wdata_i),
    .dout_o (tx_dat_sw)
  );

  wbg_lane_swap #(.W(NB), .LANE(1), .REVERSE(BIG_ENDIAN)) u_swap_sel (
    .din_i  (req_be_i),
    .dout_o (tx_sel_sw)
  );

  wbg_lane_swap #(.W(DW), .LANE(8), .REVERSE(BIG_ENDIAN)) u_swap_rxd (
    .din_i  (wb_dat_i),
    .dout_o (rx_dat_sw)
  );

  // ---------------- transfer control ----------------
  logic              cyc_q, cyc_d;
  logic              stb_q, stb_d;
  logic              lock_q;
  logic [AW-1:0]     adr_q;
  logic [DW-1:0]     dat_q;
  logic [NB-1:0]     sel_q;
  logic              we_q;
  logic [TAG_W-1:0]  tag_q;

  logic accept, lock_en, done, expire, finish, good;

  assign accept  = req_valid_i && !cyc_q && !internal;
  assign lock_en = req_valid_i && !cyc_q;
  assign done    = cyc_q && (wb_ack_i || wb_err_i);
  assign finish  = done || expire;
  assign good    = cyc_q && wb_ack_i && !wb_err_i;

  wbg_watchdog #(.TIMEOUT(TIMEOUT)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .run_i    (cyc_q),
    .kick_i   (wb_ack_i || wb_err_i),
    .expire_o (expire)
  );

  always_comb begin
    cyc_d = cyc_q;
    stb_d = stb_q;
    if (accept) begin
      cyc_d = 1'b1;
      stb_d = 1'b1;
    end else if (finish) begin
      cyc_d = 1'b0;
      stb_d = 1'b0;
    end else if (PIPELINED) begin
      stb_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      cyc_q <= cyc_d;
      stb_q <= stb_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_q <= '0;
      dat_q <= '0;
      sel_q <= '0;
      we_q  <= 1'b0;
      tag_q <= '0;
    end else if (accept) begin
      adr_q <= req_addr_i;
      dat_q <= tx_dat_sw;
      sel_q <= tx_sel_sw;
      we_q  <= req_we_i;
      tag_q <= make_tag(req_priv_i, req_fetch_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= req_lr_i;
    end
  end

  assign wb_adr_o  = adr_q;
  assign wb_dat_o  = dat_q;
  assign wb_sel_o  = sel_q;
  assign wb_we_o   = we_q;
  assign wb_tag_o  = tag_q;
  assign wb_stb_o  = stb_q;
  assign wb_cyc_o  = cyc_q;
  assign wb_lock_o = lock_q;

  // ---------------- response path ----------------
  if (ASYNC_RX) begin : g_rx_direct
    logic tmo_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tmo_q <= 1'b0;
      end else begin
        tmo_q <= expire;
      end
    end

    assign rsp_valid_o = done || tmo_q;
    assign rsp_err_o   = (cyc_q && wb_err_i) || tmo_q;
    assign rsp_rdata_o = good ? rx_dat_sw : '0;

    // R5: direct path answers in the ACK cycle
    a_r5_direct_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_cyc_o && wb_ack_i) |-> rsp_valid_o);
  end else begin : g_rx_reg
    logic          rv_q, rv_d;
    logic          re_q, re_d;
    logic [DW-1:0] rd_q, rd_d;

    always_comb begin
      rv_d = finish;
      re_d = expire || (cyc_q && wb_err_i);
      rd_d = good ? rx_dat_sw : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rv_q <= 1'b0;
        re_q <= 1'b0;
        rd_q <= '0;
      end else begin
        rv_q <= rv_d;
        re_q <= re_d;
        rd_q <= rd_d;
      end
    end

    assign rsp_valid_o = rv_q;
    assign rsp_err_o   = re_q;
    assign rsp_rdata_o = rd_q;

    // R5: registered path answers one cycle after the ACK cycle
    a_r5_reg_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_cyc_o && wb_ack_i) |=> rsp_valid_o);
  end

  // ---------------- assertions ----------------
  // R1: an internal-window request never opens a bus cycle
  a_r1_internal_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !wb_cyc_o && internal) |=> !wb_cyc_o);

  // R2: bus controls hold still while the transfer is pending
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && !wb_ack_i && !wb_err_i && !expire) |=>
      (wb_cyc_o && $stable(wb_adr_o) && $stable(wb_dat_o) && $stable(wb_sel_o)
       && $stable(wb_we_o) && $stable(wb_tag_o) && $stable(wb_lock_o)));

  if (PIPELINED) begin : g_a_pipe
    // R4: strobe lasts a single cycle within CYC
    a_r4_pipe_stb_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_stb_o |=> !wb_stb_o);
    a_r4_pipe_stb_in_cyc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_stb_o |-> wb_cyc_o);
  end else begin : g_a_classic
    // R3: classic strobe mirrors the cycle signal
    a_r3_classic_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_stb_o == wb_cyc_o);
  end

  // R6: an expiry drops CYC and reports a fault next cycle
  a_r6_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> (!wb_cyc_o && rsp_valid_o && rsp_err_o));

  // R11: the completion is a single-cycle pulse
  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R7: ERR on an open transfer ends it
  a_r7_err_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && wb_err_i) |=> !wb_cyc_o);

endmodule

// File: tb/tb_wbg_master.sv
`timescale 1ns/1ps
module tb_wbg_master;

  logic clk;
  logic rst_n;

  int checks;
  int errors;
  bit finished;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // per-unit signals: unit 0 classic/little/registered/T=16, unit 1 pipelined/big/direct/T=5
  logic        req_valid [2];
  logic [31:0] req_addr  [2];
  logic [31:0] req_wdata [2];
  logic [3:0]  req_be    [2];
  logic        req_we    [2];
  logic        req_fetch [2];
  logic        req_priv  [2];
  logic        req_lr    [2];
  logic        rsp_valid [2];
  logic [31:0] rsp_rdata [2];
  logic        rsp_err   [2];
  logic [31:0] wb_adr    [2];
  logic [31:0] wb_dato   [2];
  logic [31:0] wb_dati   [2];
  logic [3:0]  wb_sel    [2];
  logic        wb_we     [2];
  logic [2:0]  wb_tag    [2];
  logic        wb_stb    [2];
  logic        wb_cyc    [2];
  logic        wb_lock   [2];
  logic        wb_ack    [2];
  logic        wb_err    [2];

  for (genvar g = 0; g < 2; g++) begin : gen_u
    wbg_master #(
      .PIPELINED  (g == 1),
      .BIG_ENDIAN (g == 1),
      .ASYNC_RX   (g == 1),
      .TIMEOUT    ((g == 1) ? 5 : 16)
    ) dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .req_valid_i (req_valid[g]),
      .req_addr_i  (req_addr[g]),
      .req_wdata_i (req_wdata[g]),
      .req_be_i    (req_be[g]),
      .req_we_i    (req_we[g]),
      .req_fetch_i (req_fetch[g]),
      .req_priv_i  (req_priv[g]),
      .req_lr_i    (req_lr[g]),
      .rsp_valid_o (rsp_valid[g]),
      .rsp_rdata_o (rsp_rdata[g]),
      .rsp_err_o   (rsp_err[g]),
      .wb_adr_o    (wb_adr[g]),
      .wb_dat_o    (wb_dato[g]),
      .wb_sel_o    (wb_sel[g]),
      .wb_we_o     (wb_we[g]),
      .wb_tag_o    (wb_tag[g]),
      .wb_stb_o    (wb_stb[g]),
      .wb_cyc_o    (wb_cyc[g]),
      .wb_lock_o   (wb_lock[g]),
      .wb_dat_i    (wb_dati[g]),
      .wb_ack_i    (wb_ack[g]),
      .wb_err_i    (wb_err[g])
    );
  end

  function automatic bit cfg_pipe(input int u);  return u == 1; endfunction
  function automatic bit cfg_big(input int u);   return u == 1; endfunction
  function automatic bit cfg_async(input int u); return u == 1; endfunction
  function automatic int cfg_tmo(input int u);   return (u == 1) ? 5 : 16; endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [31:0] bswap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction
  function automatic logic [3:0] rev4(input logic [3:0] b);
    return {b[0], b[1], b[2], b[3]};
  endfunction

  // slave model controls (written by the stimulus) and observations (written by the slave)
  int          s_lat    [2];
  bit          s_err    [2];
  bit          s_mute   [2];
  bit          s_stray  [2];
  int          s_cnt    [2];
  int          s_len    [2];
  int          s_starts [2];
  int          s_badstb [2];
  int          s_unstab [2];
  logic [31:0] c_adr    [2];
  logic [31:0] c_dat    [2];
  logic [3:0]  c_sel    [2];
  logic        c_we     [2];
  logic [2:0]  c_tag    [2];
  logic        c_lock   [2];

  always @(negedge clk) begin
    for (int u = 0; u < 2; u++) begin
      wb_ack[u]  = 1'b0;
      wb_err[u]  = 1'b0;
      wb_dati[u] = '0;
      if (wb_cyc[u] === 1'b1) begin
        s_cnt[u]++;
        if (s_cnt[u] == 1) begin
          c_adr[u]  = wb_adr[u];
          c_dat[u]  = wb_dato[u];
          c_sel[u]  = wb_sel[u];
          c_we[u]   = wb_we[u];
          c_tag[u]  = wb_tag[u];
          c_lock[u] = wb_lock[u];
          s_starts[u]++;
          if (wb_stb[u] !== 1'b1) s_badstb[u]++;
        end else begin
          if (wb_adr[u] !== c_adr[u] || wb_dato[u] !== c_dat[u] || wb_sel[u] !== c_sel[u] ||
              wb_we[u] !== c_we[u] || wb_tag[u] !== c_tag[u] || wb_lock[u] !== c_lock[u])
            s_unstab[u]++;
          if (cfg_pipe(u) ? (wb_stb[u] !== 1'b0) : (wb_stb[u] !== 1'b1)) s_badstb[u]++;
        end
        s_len[u] = s_cnt[u];
        if (!s_mute[u] && s_cnt[u] == s_lat[u]) begin
          if (s_err[u]) wb_err[u] = 1'b1;
          else begin
            wb_ack[u]  = 1'b1;
            wb_dati[u] = mem_word(c_adr[u]);
          end
        end
      end else begin
        s_cnt[u] = 0;
        if (wb_stb[u] === 1'b1) s_badstb[u]++;
        if (s_stray[u]) begin
          wb_ack[u]  = 1'b1;
          wb_err[u]  = 1'b1;
          wb_dati[u] = 32'hDEAD_BEEF;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_req(input int u, input logic [31:0] a, input logic [31:0] wd,
                           input logic [3:0] be, input bit we, input bit fetch,
                           input bit priv, input bit lr);
    req_addr[u]  = a;
    req_wdata[u] = wd;
    req_be[u]    = be;
    req_we[u]    = we;
    req_fetch[u] = fetch;
    req_priv[u]  = priv;
    req_lr[u]    = lr;
    req_valid[u] = 1'b1;
    @(negedge clk); #1;
    req_valid[u] = 1'b0;
  endtask

  task automatic do_access(input int u, input logic [31:0] a, input logic [31:0] wd,
                           input logic [3:0] be, input bit we, input bit fetch,
                           input bit priv, input bit lr, input int lat, input bit e,
                           input bit mute);
    int k;
    int st0;
    bit exp_err;
    int exp_k;
    int exp_len;
    logic [31:0] exp_rd;
    string ltag;
    s_lat[u]  = lat;
    s_err[u]  = e;
    s_mute[u] = mute;
    @(negedge clk); #1;
    st0 = s_starts[u];
    drive_req(u, a, wd, be, we, fetch, priv, lr);
    k = 1;
    while (rsp_valid[u] !== 1'b1 && k < 60) begin
      @(negedge clk); #1;
      k++;
    end
    exp_err = mute || e;
    exp_len = mute ? cfg_tmo(u) : lat;
    exp_k   = mute ? cfg_tmo(u) + 1 : (cfg_async(u) ? lat : lat + 1);
    exp_rd  = exp_err ? 32'h0 : (cfg_big(u) ? bswap(mem_word(a)) : mem_word(a));
    ltag    = mute ? "R6 timeout response cycle" : "R5 response cycle";
    chk("R11 response seen", 32'(rsp_valid[u]), 32'd1);
    chk(ltag, 32'(k), 32'(exp_k));
    chk(e ? "R7 error flag" : "R6 error flag", 32'(rsp_err[u]), 32'(exp_err));
    chk(e ? "R7 data zero on error" : "R12 read data", rsp_rdata[u], exp_rd);
    chk("R2 one bus cycle per request", 32'(s_starts[u] - st0), 32'd1);
    chk(mute ? "R6 CYC length at timeout" : "R2 CYC length", 32'(s_len[u]), 32'(exp_len));
    chk("R2 address on bus", c_adr[u], a);
    chk("R12 write flag", 32'(c_we[u]), 32'(we));
    chk(cfg_big(u) ? "R10 write data lanes" : "R12 write data", c_dat[u],
        cfg_big(u) ? bswap(wd) : wd);
    chk(cfg_big(u) ? "R10 select lanes" : "R12 select", 32'(c_sel[u]),
        32'(cfg_big(u) ? rev4(be) : be));
    chk("R8 tag", 32'(c_tag[u]), 32'({fetch, 1'b0, priv}));
    chk("R9 lock during transfer", 32'(c_lock[u]), 32'(lr));
    chk(cfg_pipe(u) ? "R4 pipelined strobe" : "R3 classic strobe", 32'(s_badstb[u]), 32'd0);
    chk("R2 controls stable", 32'(s_unstab[u]), 32'd0);
    @(negedge clk); #1;
    chk("R11 single pulse", 32'(rsp_valid[u]), 32'd0);
  endtask

  task automatic do_internal(input int u, input logic [31:0] a, input bit lr);
    int st0;
    bit seen;
    @(negedge clk); #1;
    st0  = s_starts[u];
    seen = 1'b0;
    drive_req(u, a, 32'h1111_2222, 4'hF, 1'b1, 1'b0, 1'b1, lr);
    for (int i = 0; i < 8; i++) begin
      if (rsp_valid[u] === 1'b1 || wb_cyc[u] === 1'b1) seen = 1'b1;
      @(negedge clk); #1;
    end
    chk("R1 internal window: no CYC/response", 32'(seen), 32'd0);
    chk("R1 internal window: no bus start", 32'(s_starts[u] - st0), 32'd0);
  endtask

  task automatic stray_check(input int u);
    bit seen;
    seen = 1'b0;
    s_stray[u] = 1'b1;
    @(negedge clk); #1;
    s_stray[u] = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (rsp_valid[u] === 1'b1) seen = 1'b1;
      @(negedge clk); #1;
    end
    chk("R11 stray ACK/ERR ignored", 32'(seen), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    for (int u = 0; u < 2; u++) begin
      req_valid[u] = 1'b0;
      req_addr[u]  = '0;
      req_wdata[u] = '0;
      req_be[u]    = '0;
      req_we[u]    = 1'b0;
      req_fetch[u] = 1'b0;
      req_priv[u]  = 1'b0;
      req_lr[u]    = 1'b0;
    end
    repeat (4) @(negedge clk);
    #1;
    for (int u = 0; u < 2; u++) begin
      chk("R2 reset: CYC low", 32'(wb_cyc[u]), 32'd0);
      chk("R3 reset: STB low", 32'(wb_stb[u]), 32'd0);
      chk("R11 reset: no response", 32'(rsp_valid[u]), 32'd0);
      chk("R9 reset: lock low", 32'(wb_lock[u]), 32'd0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int u = 0; u < 2; u++) begin
      // R12 plain read and write, R8 tag corners
      do_access(u, 32'h2000_0010, 32'hA1B2_C3D4, 4'b0011, 1'b1, 1'b0, 1'b1, 1'b0, 1, 1'b0, 1'b0);
      do_access(u, 32'h2000_0014, 32'h0, 4'b1111, 1'b0, 1'b1, 1'b0, 1'b0, 2, 1'b0, 1'b0);
      do_access(u, 32'h2000_0018, 32'h55AA_33CC, 4'b1000, 1'b1, 1'b1, 1'b1, 1'b0, 3, 1'b0, 1'b0);
      // R6 ACK in the last allowed cycle, then a real timeout followed by stray ACK/ERR
      do_access(u, 32'h3000_0000, 32'h0, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, cfg_tmo(u), 1'b0, 1'b0);
      do_access(u, 32'h3000_0004, 32'h0, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b1);
      stray_check(u);
      // R7 error termination
      do_access(u, 32'h3000_0008, 32'h0, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 2, 1'b1, 1'b0);
      // R1 window edges
      do_internal(u, 32'h0000_0000, 1'b0);
      do_internal(u, 32'h0000_7FFC, 1'b0);
      do_access(u, 32'h0000_8000, 32'h0, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b0);
      do_internal(u, 32'h8000_1FFC, 1'b0);
      do_access(u, 32'h8000_2000, 32'h0, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b0);
      do_internal(u, 32'hFFFF_0000, 1'b0);
      do_access(u, 32'hFFFF_8000, 32'h0, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b0);
      do_internal(u, 32'hFFFF_FE00, 1'b0);
      do_internal(u, 32'hFFFF_FFFC, 1'b0);
      // R9 lock persistence and release
      do_access(u, 32'h4000_0000, 32'h0, 4'b1111, 1'b0, 1'b0, 1'b1, 1'b1, 2, 1'b0, 1'b0);
      repeat (5) @(negedge clk);
      #1;
      chk("R9 lock held while idle", 32'(wb_lock[u]), 32'd1);
      do_access(u, 32'h4000_0000, 32'h0, 4'b1111, 1'b0, 1'b0, 1'b1, 1'b1, 1, 1'b1, 1'b0);
      chk("R9 lock held after broken reservation", 32'(wb_lock[u]), 32'd1);
      do_internal(u, 32'h0000_0100, 1'b0);
      chk("R9 lock cleared by next request", 32'(wb_lock[u]), 32'd0);
      do_internal(u, 32'h0000_0100, 1'b1);
      chk("R9 lock set by internal reserved request", 32'(wb_lock[u]), 32'd1);
      do_access(u, 32'h4000_0004, 32'h0, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b0);
      chk("R9 lock cleared after plain access", 32'(wb_lock[u]), 32'd0);
    end

    // random accesses with mixed latency, errors and silence
    for (int u = 0; u < 2; u++) begin
      for (int n = 0; n < 60; n++) begin
        logic [31:0] a;
        logic [31:0] wd;
        logic [3:0]  be;
        int          lat;
        a   = 32'h1000_0000 | ($urandom & 32'h0FFF_FFFC);
        wd  = $urandom;
        be  = 4'($urandom);
        lat = 1 + int'($urandom % ((u == 0) ? 8 : cfg_tmo(u)));
        do_access(u, a, wd, be, 1'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom % 4) == 0, lat, ($urandom % 8) == 0, ($urandom % 10) == 0);
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule